// File: doc/BRIEF.md
# Variable-Latency Pipeline Hazard Controller

This block steers the control side of an in-order pipeline with five steps: fetch, decode, operand fetch, execute, and write back. Every step except execute lasts one clock. Execute keeps an operation for a time that depends on its opcode: one cycle for add and subtract, two for multiply, and three for divide. The controller records which instruction sits in each step. While the operation in execute still has cycles left, it freezes the three front steps and sends an empty slot into write back.

The controller compares both source tags of the instruction in operand fetch against the destination tag of the instruction in execute. A match is a read-after-write dependency. When a match exists, the dependent instruction waits. In the producer's final execute cycle, the controller flags forwarding from the execute output into operand fetch on the matching source, and the dependent moves on to execute one cycle later.

Decoded instructions arrive on a valid/ready stream. The controller holds `in_ready` low while the front is frozen. The source must then keep `in_valid` and every field steady until a cycle where both are high, and only that cycle transfers an instruction. When an instruction leaves write back, the controller raises a one-cycle completion pulse that carries the instruction's index and the current cycle number. The datapath itself, the instruction memory and the register contents belong to other blocks.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A synchronous active-high reset empties all five stages, drops the completion pulse, raises `in_ready`, and sets the cycle number to 0. An instruction flushed by reset never completes.
- R2: The cycle number rises by one on every clock after reset. An instruction accepted on the first clock after reset is in fetch during cycle 1. With no stall it passes through decode, operand fetch, execute and write back one cycle each, and it completes in cycle 5.
- R3: Opcode encoding is 00 add, 01 subtract, 10 multiply, 11 divide. Execute holds add and subtract for 1 cycle, multiply for 2 and divide for 3.
- R4: While the instruction in execute has more than one cycle left, `hold_o` is high and `in_ready` is low. Fetch, decode and operand fetch keep their contents, and write back receives an empty slot on the next cycle.
- R5: `raw_o` is high when execute and operand fetch are both occupied and either source tag in operand fetch equals the nonzero destination tag in execute.
- R6: Register tag 0 never produces a dependency, even when a source tag and the destination tag are both 0.
- R7: In the producer's last execute cycle, `fwd_a_o` (first source) and `fwd_b_o` (second source) go high for each matching source, and the dependent enters execute on the next cycle. In earlier execute cycles both stay low.
- R8: Each instruction completes in the order it was accepted. `done_valid_o` is high for one cycle and carries `done_idx_o` and the current cycle number on `done_cycle_o`. Stage occupancy is visible on `stage_valid_o`: bit 0 is fetch, bit 1 decode, bit 2 operand fetch, bit 3 execute, bit 4 write back.
- R9: An instruction is taken only on a clock where `in_valid` and `in_ready` are both high. Idle cycles on the input put nothing into the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Fetch can take an instruction this cycle |
| in_op | input | 2 | Opcode (00 add, 01 sub, 10 mul, 11 div) |
| in_rd | input | TAG_W | Destination register tag |
| in_rs1 | input | TAG_W | First source register tag |
| in_rs2 | input | TAG_W | Second source register tag |
| in_idx | input | IDX_W | Instruction index |
| hold_o | output | 1 | Front frozen, empty slot sent to write back |
| raw_o | output | 1 | Read-after-write dependency between operand fetch and execute |
| fwd_a_o | output | 1 | Forward execute result to first source |
| fwd_b_o | output | 1 | Forward execute result to second source |
| stage_valid_o | output | 5 | Occupancy per stage, bit 0 fetch to bit 4 write back |
| done_valid_o | output | 1 | Instruction leaving write back this cycle |
| done_idx_o | output | IDX_W | Index of completing instruction |
| done_cycle_o | output | CYC_W | Current cycle number |

## Verification
The main stream mixes multiply, divide, add and subtract back to back. Its dependencies fall on the first source, the second source and both sources, so a latency table that is off by one, or a hold that lets the front slip, moves every later completion cycle. The bench checks that forwarding appears only in the producer's last execute cycle and not earlier. A design that forwarded early would let the dependent start a cycle ahead, and a missing empty slot would make a finished instruction complete twice. A zero-tag pair follows a producer with destination 0, which catches a comparator that ignores the zero rule. A reset with a divide still in execute checks that a flushed instruction never completes. An idle gap in the input checks that nothing enters the pipeline while `in_valid` is low.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } hzc_op_e;
endpackage

// File: rtl/hzc_front.sv
// Fetch / decode / operand-fetch shift chain; frozen when adv is low.
module hzc_front #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             in_v,
  input  logic [W-1:0]     in_d,
  output logic [DEPTH-1:0] v_o,
  output logic [W-1:0]     last_d_o
);
  logic [DEPTH*W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= '0;
      d_q <= '0;
    end else if (adv) begin
      v_o <= {v_o[DEPTH-2:0], in_v};
      d_q <= {d_q[(DEPTH-1)*W-1:0], in_d};
    end
  end

  assign last_d_o = d_q[(DEPTH-1)*W +: W];
endmodule

// File: rtl/hzc_exec.sv
// Execute stage occupancy with an opcode-dependent residency counter.
module hzc_exec #(
  parameter int W       = 8,
  parameter int LAT_ADD = 1,
  parameter int LAT_SUB = 1,
  parameter int LAT_MUL = 2,
  parameter int LAT_DIV = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_d,
  output logic         ex_v_o,
  output logic [W-1:0] ex_d_o,
  output logic         last_o,
  output logic         busy_o
);
  import hzc_pkg::*;

  localparam int LAT_M1  = (LAT_ADD > LAT_SUB) ? LAT_ADD : LAT_SUB;
  localparam int LAT_M2  = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
  localparam int CNT_W   = $clog2(LAT_MAX + 1) < 1 ? 1 : $clog2(LAT_MAX + 1);

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] lat_sel;

  always_comb begin
    unique case (hzc_op_e'(in_op))
      OP_ADD:  lat_sel = CNT_W'(LAT_ADD);
      OP_SUB:  lat_sel = CNT_W'(LAT_SUB);
      OP_MUL:  lat_sel = CNT_W'(LAT_MUL);
      default: lat_sel = CNT_W'(LAT_DIV);
    endcase
  end

  assign busy_o = ex_v_o && (left_q > CNT_W'(1));
  assign last_o = ex_v_o && (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_v_o <= 1'b0;
      ex_d_o <= '0;
      left_q <= '0;
    end else if (busy_o) begin
      left_q <= left_q - CNT_W'(1);
    end else begin
      ex_v_o <= in_v;
      ex_d_o <= in_d;
      left_q <= in_v ? lat_sel : '0;
    end
  end
endmodule

// File: rtl/hzc_dep.sv
// Source-versus-destination comparators, one per source operand.
module hzc_dep #(
  parameter int TAG_W = 4,
  parameter int NSRC  = 2
) (
  input  logic                  ex_v,
  input  logic [TAG_W-1:0]      ex_rd,
  input  logic                  of_v,
  input  logic [NSRC*TAG_W-1:0] of_rs,
  output logic [NSRC-1:0]       hit_o
);
  logic producer_ok;
  assign producer_ok = ex_v && of_v && (ex_rd != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit_o[s] = producer_ok && (of_rs[s*TAG_W +: TAG_W] == ex_rd);
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int TAG_W   = 4,
  parameter int IDX_W   = 4,
  parameter int CYC_W   = 16,
  parameter int LAT_ADD = 1,
  parameter int LAT_SUB = 1,
  parameter int LAT_MUL = 2,
  parameter int LAT_DIV = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [TAG_W-1:0] in_rd,
  input  logic [TAG_W-1:0] in_rs1,
  input  logic [TAG_W-1:0] in_rs2,
  input  logic [IDX_W-1:0] in_idx,
  output logic             hold_o,
  output logic             raw_o,
  output logic             fwd_a_o,
  output logic             fwd_b_o,
  output logic [4:0]       stage_valid_o,
  output logic             done_valid_o,
  output logic [IDX_W-1:0] done_idx_o,
  output logic [CYC_W-1:0] done_cycle_o
);
  localparam int FRONT_N = 3;
  localparam int INS_W   = IDX_W + 2 + 3 * TAG_W;
  localparam int EXD_W   = IDX_W + TAG_W;

  logic               accept;
  logic [INS_W-1:0]   ins_in;
  logic [FRONT_N-1:0] front_v;
  logic [INS_W-1:0]   of_d;
  logic [IDX_W-1:0]   of_idx;
  logic [1:0]         of_op;
  logic [TAG_W-1:0]   of_rd, of_rs1, of_rs2;
  logic               ex_v, ex_last, ex_busy;
  logic [EXD_W-1:0]   ex_d;
  logic [TAG_W-1:0]   ex_rd;
  logic [IDX_W-1:0]   ex_idx;
  logic [1:0]         hit;
  logic               wb_v_q;
  logic [IDX_W-1:0]   wb_idx_q;
  logic [CYC_W-1:0]   cyc_q;

  assign hold_o   = ex_busy;
  assign in_ready = !ex_busy;
  assign accept   = in_valid && in_ready;
  assign ins_in   = {in_idx, in_op, in_rd, in_rs1, in_rs2};

  hzc_front #(.W(INS_W), .DEPTH(FRONT_N)) u_front (
    .clk(clk), .rst(rst), .adv(!ex_busy), .in_v(accept), .in_d(ins_in),
    .v_o(front_v), .last_d_o(of_d)
  );

  assign {of_idx, of_op, of_rd, of_rs1, of_rs2} = of_d;

  hzc_exec #(
    .W(EXD_W), .LAT_ADD(LAT_ADD), .LAT_SUB(LAT_SUB),
    .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) u_exec (
    .clk(clk), .rst(rst), .in_v(front_v[FRONT_N-1]), .in_op(of_op),
    .in_d({of_idx, of_rd}), .ex_v_o(ex_v), .ex_d_o(ex_d),
    .last_o(ex_last), .busy_o(ex_busy)
  );

  assign {ex_idx, ex_rd} = ex_d;

  hzc_dep #(.TAG_W(TAG_W), .NSRC(2)) u_dep (
    .ex_v(ex_v), .ex_rd(ex_rd), .of_v(front_v[FRONT_N-1]),
    .of_rs({of_rs2, of_rs1}), .hit_o(hit)
  );

  assign raw_o   = |hit;
  assign fwd_a_o = hit[0] && ex_last;
  assign fwd_b_o = hit[1] && ex_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_v_q   <= 1'b0;
      wb_idx_q <= '0;
      cyc_q    <= '0;
    end else begin
      wb_v_q   <= ex_last;
      wb_idx_q <= ex_idx;
      cyc_q    <= cyc_q + CYC_W'(1);
    end
  end

  assign stage_valid_o = {wb_v_q, ex_v, front_v};
  assign done_valid_o  = wb_v_q;
  assign done_idx_o    = wb_idx_q;
  assign done_cycle_o  = cyc_q;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
  parameter int TAG_W = 4,
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             hold_o,
  input logic             raw_o,
  input logic             fwd_a_o,
  input logic             fwd_b_o,
  input logic [4:0]       stage_valid_o,
  input logic             done_valid_o,
  input logic [CYC_W-1:0] done_cycle_o,
  input logic [TAG_W-1:0] ex_rd,
  input logic             ex_last
);
  a_r4_hold_blocks_input: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> !in_ready);

  a_r4_front_frozen: assert property (@(posedge clk) disable iff (rst)
    hold_o |=> $stable(stage_valid_o[2:0]));

  a_r4_wb_bubble: assert property (@(posedge clk) disable iff (rst)
    hold_o |=> !done_valid_o);

  a_r5_raw_needs_both: assert property (@(posedge clk) disable iff (rst)
    raw_o |-> (stage_valid_o[2] && stage_valid_o[3]));

  a_r6_tag0_quiet: assert property (@(posedge clk) disable iff (rst)
    (ex_rd == '0) |-> !raw_o);

  a_r7_fwd_last_only: assert property (@(posedge clk) disable iff (rst)
    (fwd_a_o || fwd_b_o) |-> (ex_last && !hold_o && raw_o));

  a_r2_cycle_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (done_cycle_o == CYC_W'($past(done_cycle_o) + 1)));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.TAG_W(TAG_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .hold_o(hold_o), .raw_o(raw_o),
  .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o), .stage_valid_o(stage_valid_o),
  .done_valid_o(done_valid_o), .done_cycle_o(done_cycle_o),
  .ex_rd(ex_rd), .ex_last(ex_last)
);

// File: tb/tb_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctrl;
  localparam int TAG_W = 4;
  localparam int IDX_W = 4;
  localparam int CYC_W = 16;
  localparam int N_TBL = 8;

  // {op[21:20], rd[19:16], rs1[15:12], rs2[11:8], expected done cycle[7:0]}
  localparam logic [21:0] TBL [N_TBL] = '{
    {2'b10, 4'd1, 4'd4, 4'd5, 8'd6},
    {2'b11, 4'd2, 4'd1, 4'd3, 8'd9},
    {2'b00, 4'd3, 4'd2, 4'd2, 8'd10},
    {2'b01, 4'd0, 4'd3, 4'd0, 8'd11},
    {2'b11, 4'd5, 4'd0, 4'd0, 8'd14},
    {2'b00, 4'd6, 4'd7, 4'd5, 8'd15},
    {2'b10, 4'd7, 4'd6, 4'd6, 8'd17},
    {2'b00, 4'd1, 4'd8, 4'd9, 8'd18}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = '0;
  logic [TAG_W-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [IDX_W-1:0] in_idx = '0;
  logic hold_o, raw_o, fwd_a_o, fwd_b_o;
  logic [4:0] stage_valid_o;
  logic done_valid_o;
  logic [IDX_W-1:0] done_idx_o;
  logic [CYC_W-1:0] done_cycle_o;

  int n_chk = 0;
  int n_bad = 0;
  int phase = 0;
  int tb_cyc = 0;
  int done_ptr = 0;
  int ev_n = 0;
  int ev_idx [8];
  int ev_cyc [8];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pipe_hazard_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .CYC_W(CYC_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_idx(in_idx), .hold_o(hold_o), .raw_o(raw_o), .fwd_a_o(fwd_a_o),
    .fwd_b_o(fwd_b_o), .stage_valid_o(stage_valid_o),
    .done_valid_o(done_valid_o), .done_idx_o(done_idx_o),
    .done_cycle_o(done_cycle_o)
  );

  always @(posedge clk) begin
    if (rst) tb_cyc <= 0;
    else     tb_cyc <= tb_cyc + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, tb_cyc);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Caller stands at a negedge; returns at the negedge after acceptance.
  task automatic send(input logic [1:0] op, input int rd, input int rs1,
                      input int rs2, input int idx);
    bit taken = 1'b0;
    in_valid = 1'b1;
    in_op = op;
    in_rd = TAG_W'(rd);
    in_rs1 = TAG_W'(rs1);
    in_rs2 = TAG_W'(rs2);
    in_idx = IDX_W'(idx);
    while (!taken) begin
      #1;
      if (in_ready) begin
        taken = 1'b1;
        @(posedge clk);
      end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Per-cycle observation away from the active edge
  always @(negedge clk) begin
    if (!rst && phase == 1) begin
      if (done_valid_o) begin
        if (done_ptr < N_TBL) begin
          check("R8 completion index", int'(done_idx_o), done_ptr);
          check("R3 completion cycle", int'(done_cycle_o), int'(TBL[done_ptr][7:0]));
          check("R2 cycle number", int'(done_cycle_o), tb_cyc);
        end else begin
          check("R8 extra completion", 1, 0);
        end
        done_ptr++;
      end
      case (tb_cyc)
        4: begin
          check("R4 hold during multiply", int'(hold_o), 1);
          check("R4 ready low while held", int'(in_ready), 0);
          check("R5 raw on first source", int'(raw_o), 1);
          check("R7 no early forward", int'(fwd_a_o), 0);
          check("R8 occupancy", int'(stage_valid_o), 5'b01111);
        end
        5: begin
          check("R7 forward first source", int'(fwd_a_o), 1);
          check("R7 second source quiet", int'(fwd_b_o), 0);
          check("R4 hold released", int'(hold_o), 0);
        end
        7: check("R4 write back bubble", int'(done_valid_o), 0);
        8: begin
          check("R7 forward both a", int'(fwd_a_o), 1);
          check("R7 forward both b", int'(fwd_b_o), 1);
        end
        10: check("R6 zero tag no dependency", int'(raw_o), 0);
        11: begin
          check("R5 raw on second source", int'(raw_o), 1);
          check("R7 divide early b quiet", int'(fwd_b_o), 0);
        end
        13: begin
          check("R7 forward second source", int'(fwd_b_o), 1);
          check("R7 first source quiet", int'(fwd_a_o), 0);
        end
        default: ;
      endcase
    end
    if (!rst && phase == 2 && done_valid_o) begin
      if (ev_n < 8) begin
        ev_idx[ev_n] = int'(done_idx_o);
        ev_cyc[ev_n] = int'(done_cycle_o);
      end
      ev_n++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      report();
    end
  end

  initial begin
    do_reset();
    // R1: state right after reset
    check("R1 stages empty", int'(stage_valid_o), 0);
    check("R1 no completion", int'(done_valid_o), 0);
    check("R1 ready", int'(in_ready), 1);
    check("R1 cycle zero", int'(done_cycle_o), 0);

    phase = 1;
    for (int i = 0; i < N_TBL; i++) begin
      send(TBL[i][21:20], int'(TBL[i][19:16]), int'(TBL[i][15:12]),
           int'(TBL[i][11:8]), i);
    end
    idle(12);
    check("R8 all completed", done_ptr, N_TBL);

    // Reset with a divide still in execute
    phase = 2;
    ev_n = 0;
    do_reset();
    send(2'b11, 1, 0, 0, 12);
    send(2'b00, 2, 1, 0, 13);
    idle(2);
    check("R3 divide in execute", int'(stage_valid_o[3]), 1);
    do_reset();
    check("R1 flush stages empty", int'(stage_valid_o), 0);
    check("R1 flush no completion", int'(done_valid_o), 0);
    check("R1 flush cycle zero", int'(done_cycle_o), 0);
    check("R1 flush ready", int'(in_ready), 1);

    // R2 lone add, then R9 idle gap before a subtract
    send(2'b00, 2, 0, 0, 3);
    idle(2);
    send(2'b01, 3, 2, 0, 4);
    idle(8);
    check("R1 flushed never complete", ev_n, 2);
    check("R2 lone add index", ev_idx[0], 3);
    check("R2 lone add cycle", ev_cyc[0], 5);
    check("R9 after gap index", ev_idx[1], 4);
    check("R9 after gap cycle", ev_cyc[1], 8);

    finished = 1'b1;
    report();
  end
endmodule